// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the protocol engine of a byte-wide serial EEPROM that sits on a two-wire bus. It receives SCL and SDA samples that have already been synchronized and deglitched in the system clock domain. It answers the bus through an open-drain pull-down enable. The block recognises bus start and stop conditions and checks the device select word. It assembles the 11-bit memory address and performs byte and page writes, as well as current-address, random and sequential reads. It reaches storage through a simple synchronous single-port memory interface, with one cycle of read latency.

When a write transaction ends with at least one byte committed, the engine models the nonvolatile programming time with a cycle counter. During that time it ignores every device select word. A bus master can therefore poll for completion by repeatedly sending a write select and watching for the acknowledge. The address counter steps differently for writes and for reads. After a data byte is written, it advances only inside the current 32-byte page. After a byte is read, it advances across the whole array.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) begins reception of a select word from any state. A stop condition (SDA rising while SCL is high) returns the engine to idle, and the engine releases SDA at once.
- R2: The select word is sent MSB first. Bits [7:4] must be 4'b1010, or the engine gives no acknowledge and goes idle. Bit 0 chooses the direction: 1 is read, 0 is write.
- R3: After each received byte it accepts (select word, address byte, write data byte), the engine pulls SDA low for the ninth SCL clock. The engine changes its SDA drive only while SCL is low.
- R4: With ADDR_W = 11, bits [3:1] of a write select word become address bits [10:8], and the next byte becomes address bits [7:0]. When ADDR_W is below 11, the top select bits are compared with dev_sel_i instead.
- R5: Each write data byte is stored at the counter address. The counter's low 5 bits then step by one and wrap inside the page. After a write, the counter points one past the last byte written, within the same page.
- R6: Read data is shifted out MSB first, and each bit is changed after an SCL falling edge. If the master drives 0 on the ninth clock, the engine sends the next byte. If the master drives 1, the engine releases SDA and stays released.
- R7: A read select that follows a write select and an address byte, with a repeated start in between, returns data from that address. A read select with no preceding address returns data from the counter value.
- R8: After each byte is read, the counter steps by one over the full array, and address 2047 wraps to 0.
- R9: The internal write cycle lasts WR_CYCLES clocks. It begins when a stop or a repeated start ends a transaction in which at least one byte was committed. During that cycle, no select word of either direction is acknowledged.
- R10: While wp_i is high, write data bytes are still acknowledged, but memory is not modified and no write cycle begins.
- R11: A stop in the middle of a byte commits nothing and does not begin a write cycle.
- R12: A repeated start in the middle of a byte restarts the bit count and the select-word reception.
- R13: After reset the counter is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized bus clock sample |
| sda_i | input | 1 | Synchronized bus data sample |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| dev_sel_i | input | 3 | Hard-wired select bits, compared only when ADDR_W < 11 |
| wp_i | input | 1 | Write protect: 1 blocks memory updates |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe, one clock |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the address |

## Verification
The bench builds the block with ADDR_W = 11, so the upper address bits always come from the select word. It uses WR_CYCLES = 600, which makes the write cycle last a few bus bytes. A poll issued right after a stop is therefore refused, and later polls are acknowledged. SCL runs at 12 system clocks per bit, which leaves several cycles between the address update and the read-data load. With these settings the bench can reach the page wrap at offsets 30–31, the array wrap at 2047, partial-byte aborts and write-protected writes within a short run.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK
  } st_e;
endpackage

// File: rtl/twi_cond_det.sv
module twi_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_page_i,
  input  logic              inc_full_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         addr_q <= '0;
    else if (load_i)     addr_q <= load_val_i;
    else if (inc_page_i) addr_q <= {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
    else if (inc_full_i) addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/twi_wr_timer.sv
module twi_wr_timer #(
  parameter int WR_CYCLES = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic busy_o
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (kick_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_ee_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYCLES  = 4000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        dev_sel_i,
  input  logic              wp_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int HI_W   = ADDR_W - 8;            // 1..3 address bits in select word
  localparam logic [2:0] CMP_MASK = 3'(7 << HI_W); // select bits compared with pins

  logic scl_rise, scl_fall, start_c, stop_c;
  logic wr_busy;

  st_e             st_q, st_d;
  logic [3:0]      cnt_q, cnt_d;
  logic [7:0]      rx_q, rx_d;
  logic [6:0]      tx_q, tx_d;
  logic            oe_q, oe_d;
  logic            rd_q, rd_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic            wrote_q, wrote_d;
  logic            mack_q, mack_d;

  logic              ctr_ld, ctr_incp, ctr_incf, we_c, kick_c, dev_ok;
  logic [ADDR_W-1:0] ctr_val;

  twi_cond_det u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  twi_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk_i, .rst_ni,
    .load_i(ctr_ld), .load_val_i(ctr_val),
    .inc_page_i(ctr_incp), .inc_full_i(ctr_incf),
    .addr_o(mem_addr_o)
  );

  twi_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk_i, .rst_ni, .kick_i(kick_c), .busy_o(wr_busy)
  );

  // R2 R4 R9: code, pin compare, busy refusal
  assign dev_ok = (rx_q[7:4] == DEV_CODE) &&
                  (((rx_q[3:1] ^ dev_sel_i) & CMP_MASK) == 3'b000) && !wr_busy;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; rx_d = rx_q; tx_d = tx_q; oe_d = oe_q;
    rd_d = rd_q; hi_d = hi_q; wrote_d = wrote_q; mack_d = mack_q;
    ctr_ld = 1'b0; ctr_val = {hi_q, rx_q}; ctr_incp = 1'b0; ctr_incf = 1'b0;
    we_c = 1'b0; kick_c = 1'b0;
    if (stop_c) begin                         // R1 R11
      st_d = ST_IDLE; oe_d = 1'b0; kick_c = wrote_q; wrote_d = 1'b0;
    end else if (start_c) begin               // R1 R12
      st_d = ST_DEV; cnt_d = '0; oe_d = 1'b0; kick_c = wrote_q; wrote_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_ADDR, ST_WDAT: begin
          if (scl_rise && cnt_q != 4'd8) begin
            rx_d  = {rx_q[6:0], sda_i};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (st_q == ST_DEV) begin
              if (dev_ok) begin
                oe_d = 1'b1; st_d = ST_DEV_ACK; rd_d = rx_q[0];
                if (!rx_q[0]) hi_d = rx_q[HI_W:1];
              end else begin
                st_d = ST_IDLE;
              end
            end else if (st_q == ST_ADDR) begin
              oe_d = 1'b1; st_d = ST_ADDR_ACK; ctr_ld = 1'b1;
            end else begin                     // R5 R10
              oe_d = 1'b1; st_d = ST_WDAT_ACK; ctr_incp = 1'b1;
              we_c = !wp_i;
              if (!wp_i) wrote_d = 1'b1;
            end
          end
        end
        ST_DEV_ACK, ST_ADDR_ACK, ST_WDAT_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (st_q == ST_DEV_ACK && rd_q) begin
              st_d = ST_RDAT; tx_d = mem_rdata_i[6:0]; oe_d = !mem_rdata_i[7];
            end else begin
              oe_d = 1'b0;
              st_d = (st_q == ST_DEV_ACK) ? ST_ADDR : ST_WDAT;
            end
          end
        end
        ST_RDAT: begin
          if (scl_rise && cnt_q != 4'd8) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin           // R8
              oe_d = 1'b0; st_d = ST_RACK; ctr_incf = 1'b1;
            end else begin                     // R6
              tx_d = {tx_q[5:0], 1'b0}; oe_d = !tx_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_d = !sda_i;
          else if (scl_fall) begin
            cnt_d = '0;
            if (mack_q) begin
              st_d = ST_RDAT; tx_d = mem_rdata_i[6:0]; oe_d = !mem_rdata_i[7];
            end else begin
              st_d = ST_IDLE; oe_d = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; rx_q <= '0; tx_q <= '0; oe_q <= 1'b0;
      rd_q <= 1'b0; hi_q <= '0; wrote_q <= 1'b0; mack_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; rx_q <= rx_d; tx_q <= tx_d; oe_q <= oe_d;
      rd_q <= rd_d; hi_q <= hi_d; wrote_q <= wrote_d; mack_q <= mack_d;
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_we_o    = we_c;
  assign mem_wdata_o = rx_q;
endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_i,
  input logic              sda_oe_o,
  input logic              wp_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              busy_i
);
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i); // R3

  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> !sda_oe_o); // R1

  AST_WP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !wp_i); // R10

  AST_BUSY_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !mem_we_o); // R9

  AST_PAGE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mem_we_o) |-> mem_addr_o[ADDR_W-1:5] == $past(mem_addr_o[ADDR_W-1:5])); // R5
endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
  .sda_oe_o(sda_oe_o), .wp_i(wp_i), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .busy_i(wr_busy)
);

// File: tb/twi_eeprom_slave_test.sv
module twi_eeprom_slave_test;
  localparam int AW = 11;
  localparam int MEMN = 2048;
  localparam int WRC = 600;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, we, sda_line;
  logic [AW-1:0] maddr;
  logic [7:0] wdat, rdat;
  logic [7:0] mem [MEMN];
  logic [7:0] ref_m [MEMN];
  logic [7:0] wbuf [32];
  logic [AW-1:0] ref_ctr = '0;
  int errs = 0, checks = 0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  twi_eeprom_slave #(.ADDR_W(AW), .PAGE_BYTES(32), .WR_CYCLES(WRC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .dev_sel_i(3'b000), .wp_i(wp),
    .mem_addr_o(maddr), .mem_wdata_o(wdat), .mem_we_o(we), .mem_rdata_i(rdat)
  );

  always @(posedge clk) begin
    if (we) mem[maddr] <= wdat;
    rdat <= mem[maddr];
  end

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [AW-1:0] pg(input logic [AW-1:0] a, input int k);
    return {a[AW-1:5], 5'(int'(a[4:0]) + k)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half; repeat (Q) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b1; half; scl_m = 1'b1; half; sda_m = 1'b0; half; scl_m = 1'b0;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; half; scl_m = 1'b1; half; sda_m = 1'b1; half;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; half; scl_m = 1'b1; half; scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; half; scl_m = 1'b1; ack = sda_line; half; scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      half; scl_m = 1'b1; b[i] = sda_line; half; scl_m = 1'b0;
    end
    sda_m = mack; half; scl_m = 1'b1; half; scl_m = 1'b0;
  endtask

  task automatic wait_ready(output int polls);
    logic ack;
    polls = 0;
    do begin
      bus_start; send_byte(8'hA0, ack); bus_stop;
      if (ack) polls++;
    end while (ack && polls < 300);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input int n, input string tag);
    logic ack;
    bus_start;
    send_byte({4'hA, a[10:8], 1'b0}, ack); chk(ack == 0, "R3 select ack", ack, 0);
    send_byte(a[7:0], ack);                chk(ack == 0, "R3 address ack", ack, 0);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack); chk(ack == 0, tag, ack, 0);
      if (!wp) ref_m[pg(a, k)] = wbuf[k];
    end
    bus_stop;
    ref_ctr = pg(a, n);
  endtask

  task automatic read_tail(input int n, input logic [AW-1:0] base, input string tag);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, b);
      chk(b == ref_m[AW'(int'(base) + k)], tag, b, ref_m[AW'(int'(base) + k)]);
    end
    repeat (2) @(negedge clk);
    chk(sda_oe == 0, "R6 release after master nack", sda_oe, 0);
    bus_stop;
    ref_ctr = AW'(int'(base) + n);
  endtask

  task automatic do_rand_read(input logic [AW-1:0] a, input int n, input string tag);
    logic ack;
    bus_start;
    send_byte({4'hA, a[10:8], 1'b0}, ack); send_byte(a[7:0], ack);
    bus_start;
    send_byte(8'hA1, ack); chk(ack == 0, "R7 read select ack", ack, 0);
    read_tail(n, a, tag);
  endtask

  task automatic do_cur_read(input int n, input string tag);
    logic ack;
    bus_start;
    send_byte(8'hA1, ack); chk(ack == 0, "R7 current select ack", ack, 0);
    read_tail(n, ref_ctr, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog (all requirements): actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic ack;
    int polls;
    for (int i = 0; i < MEMN; i++) begin
      mem[i] = init_val(i); ref_m[i] = init_val(i);
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    half;
    chk(sda_oe == 0, "R13 SDA released after reset", sda_oe, 0);
    chk(we == 0, "R13 no write after reset", we, 0);
    do_cur_read(2, "R13 counter starts at 0");

    bus_start; send_byte(8'hB0, ack);
    chk(ack == 1, "R2 wrong code refused", ack, 1);
    bus_stop;

    wbuf[0] = 8'h3C;
    do_write(11'h5A7, 1, "R4 data ack");
    wait_ready(polls);
    chk(polls > 0, "R9 poll refused while busy", polls, 1);
    do_rand_read(11'h5A7, 1, "R4 high bits from select word");

    wbuf[0] = 8'h99;
    do_write(11'h010, 1, "R5 data ack");
    bus_start; send_byte(8'hA1, ack);
    chk(ack == 1, "R9 read select refused while busy", ack, 1);
    bus_stop;
    wait_ready(polls);

    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    do_write(11'h29E, 4, "R5 page data ack");
    wait_ready(polls);
    do_cur_read(1, "R5 counter wraps in page");
    do_rand_read(11'h29E, 2, "R5 page tail");
    do_rand_read(11'h280, 3, "R5 page wrap head");

    wbuf[0] = 8'h5E;
    do_write(11'h3FF, 1, "R5 last offset ack");
    wait_ready(polls);
    do_cur_read(1, "R5 counter after last offset");

    do_rand_read(11'h7FE, 4, "R8 array wrap");
    do_cur_read(1, "R8 counter after wrap");

    wp = 1'b1; wbuf[0] = 8'hEE; wbuf[1] = 8'hDD;
    do_write(11'h123, 2, "R10 protected data still acked");
    wp = 1'b0;
    wait_ready(polls);
    chk(polls == 0, "R10 no write cycle when protected", polls, 0);
    do_rand_read(11'h123, 2, "R10 memory unchanged");

    bus_start; send_byte(8'hA0, ack); send_byte(8'h80, ack);
    send_bits(8'h00, 3); bus_stop;
    chk(sda_oe == 0, "R1 released after stop", sda_oe, 0);
    bus_start; send_byte(8'hA0, ack);
    chk(ack == 0, "R11 no write cycle after aborted byte", ack, 0);
    bus_stop;
    do_rand_read(11'h080, 1, "R11 aborted byte not stored");

    bus_start; send_byte(8'hA0, ack); send_byte(8'h40, ack);
    send_bits(8'h0F, 4);
    bus_start; send_byte(8'hA1, ack);
    chk(ack == 0, "R12 select after mid-byte restart", ack, 0);
    read_tail(1, 11'h040, "R12 data after restart");

    void'($urandom(32'h5EED));
    for (int it = 0; it < 16; it++) begin
      logic [AW-1:0] a;
      int n;
      a = AW'($urandom % MEMN);
      n = 1 + int'($urandom % 6);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      wp = ($urandom % 4 == 0);
      do_write(a, n, "R5 random write ack");
      wp = 1'b0;
      wait_ready(polls);
      if ($urandom % 2 == 1) do_cur_read(1 + int'($urandom % 3), "R7 random current read");
      else do_rand_read(a, n, "R8 random readback");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule